// File: doc/BRIEF.md
# ADC Capture Controller with Guarded Pump Enable

This block is the register-side controller of a 12-bit analog-to-digital converter. A host reaches it through a simple register port: one strobe writes a byte, one strobe reads a byte, and there is an address. A separate strobe marks the end of each bus transaction. The converter is driven through a start pulse. It answers with a done pulse and a 12-bit sample. The controller can run a single conversion on request. It can also sample periodically at one of four rates, with each new sample replacing the last.

A charge pump enable sits behind a two-step guard. An arm bit has to be written first, in one transaction. An unlock code then has to be written in a later transaction. Any other order leaves the pump off.

The 12-bit result is read as a low byte and a high byte. Once the host has read one of them, the visible value is frozen until both bytes have been read, so the two bytes always come from one sample. A sample that finishes while the value is frozen is parked and shown when the freeze ends.

Top module: `adc_cap_top`

## Requirements
- R1: After reset the control register (address 0x20) reads 0x33, both result bytes read 0x00, pumpOn is 0 and no start pulse is issued.
- R2: Control register fields: bit7 selects the mode (0 periodic, 1 single), bit6 is capture, bits5:4 are the rate code, bit3 is arm, bits2:1 are the unlock code, and bit0 always reads 1.
- R3: In periodic mode with capture written 1, the first adcStart pulse comes one cycle after the write. Later pulses are 100, 80, 67 or 50 cycles apart for rate codes 00, 01, 10 and 11, with each count multiplied by CLKS_PER_US.
- R4: In periodic mode, writing capture 0 stops the start pulses, and each completed sample replaces the visible result.
- R5: In single mode, writing capture 1 produces exactly one start pulse and capture reads 1 until adcDone. Writing 0, or writing 1 while a conversion is running, starts nothing.
- R6: A single-mode completion gives a one-cycle irqEvent pulse in the cycle after adcDone. Periodic completions give none.
- R7: An unlock code write has no effect while arm is 0.
- R8: With arm set in an earlier transaction, unlock code 01 turns the pump on. Any unlock write clears arm, and codes 00, 10 and 11 leave the pump as it was. Once on, the pump stays on until reset.
- R9: Arm and unlock writes in the same transaction (no txnEnd between them) do not turn the pump on.
- R10: The unlock field reads 00 while the pump is on and 01 while it is off.
- R11: The result is right-aligned. Address 0x21 gives bits 7:0, and address 0x22 gives bits 11:8 with its upper four bits zero.
- R12: After either result byte is read, both bytes keep showing the same sample. The freeze ends when both bytes have been read or when any other address is accessed.
- R13: A sample that completes during a freeze is shown once the freeze ends. If several complete, only the newest is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Register address |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| txnEnd | input | 1 | End of a bus transaction |
| adcStart | output | 1 | Conversion start pulse |
| adcDone | input | 1 | Conversion complete pulse |
| adcData | input | 12 | Converted sample, valid with adcDone |
| pumpOn | output | 1 | Charge pump enable |
| irqEvent | output | 1 | Single-conversion completion pulse |

## Verification
Each internal state has its own symptom at the ports:
- A stuck busy flag shows up when the control register is read right after a conversion: capture still reads 1, and the next single-mode write starts nothing.
- A wrong rate timer shows up on the second adcStart pulse, because the spacing between pulses is off.
- A wrong arm or freshness flag shows up in the same cycle as the unlock write: pumpOn rises when it should not, or the control register gets an arm bit or unlock field that disagrees with the expected value.
- A broken freeze or pending register shows up on the second byte read after a sample lands between the two reads: that read returns a byte from a different sample, or a later read returns a stale value.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  // strobes from the control side to the result datapath
  typedef struct packed {
    logic rdLo;
    logic rdHi;
    logic accOther;
  } dpStrobe_t;
endpackage

// File: rtl/adc_cap_ctrl.sv
module adc_cap_ctrl
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CLKS_PER_US = 1,
  parameter logic [7:0] CTRL_ADDR = 8'h20,
  parameter logic [7:0] LO_ADDR = 8'h21,
  parameter logic [7:0] HI_ADDR = 8'h22
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [7:0]        regWrData,
  input  logic              txnEnd,
  input  logic              adcDone,
  input  logic [DATA_W-1:0] result,
  output logic [7:0]        regRdData,
  output logic              adcStart,
  output logic              pumpOn,
  output logic              irqEvent,
  output dpStrobe_t         strobe
);
  localparam int IV0 = 100 * CLKS_PER_US;
  localparam int IV1 = 80 * CLKS_PER_US;
  localparam int IV2 = 67 * CLKS_PER_US;
  localparam int IV3 = 50 * CLKS_PER_US;
  localparam int TIMER_W = $clog2(IV0 + 1);

  function automatic logic [TIMER_W-1:0] intervalOf(input logic [1:0] code);
    case (code)
      2'b00:   return TIMER_W'(IV0 - 1);
      2'b01:   return TIMER_W'(IV1 - 1);
      2'b10:   return TIMER_W'(IV2 - 1);
      default: return TIMER_W'(IV3 - 1);
    endcase
  endfunction

  logic modeQ, runQ, busyQ, armQ, armFreshQ, pumpQ, startQ, irqQ;
  logic [1:0] rateQ;
  logic [TIMER_W-1:0] timerQ;

  logic wrCtrl, newMode, newCap, newArm, armedEarlier;
  logic [1:0] newRate, newCode;
  logic unusedBit;

  assign wrCtrl       = regWrEn && (regAddr == CTRL_ADDR);
  assign newMode      = regWrData[7];
  assign newCap       = regWrData[6];
  assign newRate      = regWrData[5:4];
  assign newArm       = regWrData[3];
  assign newCode      = regWrData[2:1];
  assign unusedBit    = regWrData[0];
  assign armedEarlier = armQ && !armFreshQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= 1'b0;
      runQ      <= 1'b0;
      busyQ     <= 1'b0;
      rateQ     <= 2'b11;
      armQ      <= 1'b0;
      armFreshQ <= 1'b0;
      pumpQ     <= 1'b0;
      startQ    <= 1'b0;
      irqQ      <= 1'b0;
      timerQ    <= '0;
    end else begin
      startQ <= 1'b0;
      irqQ   <= 1'b0;
      if (txnEnd) armFreshQ <= 1'b0;
      if (adcDone && busyQ) begin
        busyQ <= 1'b0;
        irqQ  <= 1'b1;
      end
      if (runQ) begin
        if (timerQ == '0) begin
          startQ <= 1'b1;
          timerQ <= intervalOf(rateQ);
        end else begin
          timerQ <= timerQ - 1'b1;
        end
      end
      if (wrCtrl) begin
        modeQ <= newMode;
        rateQ <= newRate;
        if (newMode) begin
          runQ <= 1'b0;
          if (newCap && !busyQ) begin
            busyQ  <= 1'b1;
            startQ <= 1'b1;
          end
        end else begin
          runQ <= newCap;
          if (newCap && !runQ) timerQ <= '0;
        end
        if (armedEarlier) begin
          armQ <= 1'b0;
          if (newCode == 2'b01) pumpQ <= 1'b1;
        end else begin
          armQ      <= newArm;
          armFreshQ <= newArm;
        end
      end
    end
  end

  always_comb begin
    regRdData = 8'h00;
    if (regAddr == CTRL_ADDR)
      regRdData = {modeQ, (modeQ ? busyQ : runQ), rateQ, armQ,
                   (pumpQ ? 2'b00 : 2'b01), 1'b1};
    else if (regAddr == LO_ADDR)
      regRdData = result[7:0];
    else if (regAddr == HI_ADDR)
      regRdData = {{(16-DATA_W){1'b0}}, result[DATA_W-1:8]};
  end

  assign strobe.rdLo     = regRdEn && (regAddr == LO_ADDR);
  assign strobe.rdHi     = regRdEn && (regAddr == HI_ADDR);
  assign strobe.accOther = (regRdEn || regWrEn) &&
                           (regAddr != LO_ADDR) && (regAddr != HI_ADDR);

  assign adcStart = startQ;
  assign pumpOn   = pumpQ;
  assign irqEvent = irqQ;

  // single-mode start only issued with a conversion in flight
  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (startQ && modeQ) |-> busyQ);
  // busy drops only when the converter reports completion
  assert_busy_done_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyQ) |-> $past(adcDone));
  // completion pulse only follows a single-mode done
  assert_irq_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqQ |-> ($past(busyQ) && $past(adcDone)));
  // pump enable requires arm from an earlier transaction
  assert_pump_guard_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pumpQ) |-> ($past(armQ) && !$past(armFreshQ) && $past(wrCtrl)));
  // pump never drops once on
  assert_pump_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(pumpQ) |-> pumpQ);
endmodule

// File: rtl/adc_cap_dp.sv
module adc_cap_dp
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              adcDone,
  input  logic [DATA_W-1:0] adcData,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] resultQ, pendQ;
  logic pendValidQ, frozenQ, seenLoQ, seenHiQ;
  logic release_, startFreeze;

  assign release_ = frozenQ && (strobe.accOther ||
                    ((strobe.rdLo || seenLoQ) && (strobe.rdHi || seenHiQ)));
  assign startFreeze = !frozenQ && (strobe.rdLo || strobe.rdHi);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ    <= '0;
      pendQ      <= '0;
      pendValidQ <= 1'b0;
      frozenQ    <= 1'b0;
      seenLoQ    <= 1'b0;
      seenHiQ    <= 1'b0;
    end else if (release_) begin
      frozenQ    <= 1'b0;
      seenLoQ    <= 1'b0;
      seenHiQ    <= 1'b0;
      pendValidQ <= 1'b0;
      if (adcDone)         resultQ <= adcData;
      else if (pendValidQ) resultQ <= pendQ;
    end else if (frozenQ || startFreeze) begin
      frozenQ <= 1'b1;
      if (strobe.rdLo) seenLoQ <= 1'b1;
      if (strobe.rdHi) seenHiQ <= 1'b1;
      if (adcDone) begin
        pendQ      <= adcData;
        pendValidQ <= 1'b1;
      end
    end else if (adcDone) begin
      resultQ <= adcData;
    end
  end

  assign result = resultQ;

  // visible sample held across a freeze that is not ending
  assert_frozen_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (frozenQ && !strobe.accOther && !strobe.rdLo && !strobe.rdHi) |=> $stable(resultQ));
  // nothing parked unless frozen
  assert_pending_frozen_R13: assert property (@(posedge clk) disable iff (!rstN)
    pendValidQ |-> frozenQ);
endmodule

// File: rtl/adc_cap_top.sv
module adc_cap_top
  import adc_cap_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CLKS_PER_US = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [7:0]        regWrData,
  output logic [7:0]        regRdData,
  input  logic              txnEnd,
  output logic              adcStart,
  input  logic              adcDone,
  input  logic [DATA_W-1:0] adcData,
  output logic              pumpOn,
  output logic              irqEvent
);
  dpStrobe_t strobe;
  logic [DATA_W-1:0] result;

  adc_cap_ctrl #(.DATA_W(DATA_W), .CLKS_PER_US(CLKS_PER_US)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .txnEnd(txnEnd),
    .adcDone(adcDone), .result(result), .regRdData(regRdData),
    .adcStart(adcStart), .pumpOn(pumpOn), .irqEvent(irqEvent),
    .strobe(strobe)
  );

  adc_cap_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .adcDone(adcDone), .adcData(adcData),
    .strobe(strobe), .result(result)
  );
endmodule

// File: tb/sim_adc_cap_top.sv
module sim_adc_cap_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, txnEnd = 1'b0;
  logic [7:0] regAddr = 8'h00, regWrData = 8'h00;
  logic [7:0] regRdData;
  logic adcStart, pumpOn, irqEvent;
  logic adcDone = 1'b0;
  logic [11:0] nextVal = 12'h000;
  int latCnt = 0;

  int nChecks = 0, nFail = 0, cyc = 0;
  int startCount = 0, irqCount = 0;
  int expQ[$];
  int lastStart = 0;
  bit haveLast = 0;

  always #5 clk = ~clk;

  adc_cap_top u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .txnEnd(txnEnd), .adcStart(adcStart), .adcDone(adcDone),
    .adcData(nextVal), .pumpOn(pumpOn), .irqEvent(irqEvent)
  );

  // converter model with a fixed latency of 5 cycles
  always @(posedge clk) begin
    adcDone <= 1'b0;
    if (adcStart) latCnt <= 5;
    else if (latCnt != 0) begin
      latCnt <= latCnt - 1;
      if (latCnt == 1) adcDone <= 1'b1;
    end
  end

  always @(posedge clk) cyc++;

  task automatic check(input string tag, input int got, input int exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  // monitor: pops expected start spacing as pulses appear
  always @(negedge clk) begin
    if (adcStart) begin
      startCount++;
      if (haveLast && expQ.size() > 0) check("R3 start interval", cyc - lastStart, expQ.pop_front());
      lastStart = cyc;
      haveLast = 1;
    end
    if (irqEvent) irqCount++;
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); regRdEn = 1'b1; regAddr = a; #1 d = regRdData;
    @(negedge clk); regRdEn = 1'b0;
  endtask

  task automatic endTxn();
    @(negedge clk); txnEnd = 1'b1;
    @(negedge clk); txnEnd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: pushes expected spacing for one rate code
  task automatic runRate(input int code, input int spacing);
    haveLast = 0;
    for (int i = 0; i < 3; i++) expQ.push_back(spacing);
    wr(8'h20, 8'h40 | 8'(code << 4));
    idle(4 * spacing + 10);
    wr(8'h20, 8'(code << 4));
    check("R3 all intervals seen", expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int s0, i0;
    idle(3);
    rstN = 1'b1;
    idle(2);

    // R1 reset state
    rd(8'h20, d); check("R1 ctrl reset", d, 8'h33);
    rd(8'h21, d); check("R1 lo reset", d, 8'h00);
    rd(8'h22, d); check("R1 hi reset", d, 8'h00);
    check("R1 pump off", pumpOn, 0);
    check("R1 no start", startCount, 0);

    // R5/R6 single conversion
    nextVal = 12'hABC;
    s0 = startCount; i0 = irqCount;
    wr(8'h20, 8'hF0);
    rd(8'h20, d); check("R5 capture reads busy", d[6], 1);
    check("R2 mode bit", d[7], 1);
    check("R2 rate field", d[5:4], 3);
    idle(15);
    check("R5 one start", startCount - s0, 1);
    check("R6 one irq", irqCount - i0, 1);
    rd(8'h20, d); check("R5 capture done", d[6], 0);
    rd(8'h21, d); check("R11 lo byte", d, 8'hBC);
    rd(8'h22, d); check("R11 hi byte zero-padded", d, 8'h0A);
    s0 = startCount;
    wr(8'h20, 8'hB0); idle(10);
    check("R5 write 0 starts nothing", startCount - s0, 0);
    wr(8'h20, 8'hF0); wr(8'h20, 8'hF0); idle(15);
    check("R5 write while busy ignored", startCount - s0, 1);

    // R3/R4/R6 periodic rates
    i0 = irqCount;
    runRate(0, 100);
    runRate(1, 80);
    runRate(2, 67);
    runRate(3, 50);
    check("R6 no irq in periodic", irqCount - i0, 0);
    s0 = startCount; idle(150);
    check("R4 stopped", startCount - s0, 0);
    nextVal = 12'h345;
    wr(8'h20, 8'h70); idle(20);
    nextVal = 12'h678; idle(55);
    wr(8'h20, 8'h30);
    rd(8'h21, d); check("R4 newest overwrites lo", d, 8'h78);
    rd(8'h22, d); check("R4 newest overwrites hi", d, 8'h06);

    // R12/R13 coherence
    nextVal = 12'hABC;
    wr(8'h20, 8'h70); idle(15);
    rd(8'h21, d); check("R12 first lo", d, 8'hBC);
    nextVal = 12'h5D7; idle(60);
    rd(8'h22, d); check("R12 hi from frozen sample", d, 8'h0A);
    rd(8'h21, d); check("R13 pending shown lo", d, 8'hD7);
    rd(8'h22, d); check("R13 pending shown hi", d, 8'h05);
    nextVal = 12'h2E1;
    rd(8'h21, d); check("R12 lo before other access", d, 8'hD7);
    idle(40);
    rd(8'h20, d);
    rd(8'h22, d); check("R12 other access releases hi", d, 8'h02);
    rd(8'h21, d); check("R12 other access releases lo", d, 8'hE1);
    wr(8'h20, 8'h30);
    endTxn();

    // R7..R10 pump guard
    wr(8'h20, 8'hB2);
    rd(8'h20, d); check("R7 unlock ignored unarmed", d, 8'hB3);
    check("R7 pump off", pumpOn, 0);
    wr(8'h20, 8'hBA);
    rd(8'h20, d); check("R9 arm+unlock same write", d, 8'hBB);
    wr(8'h20, 8'hB2);
    rd(8'h20, d); check("R9 unlock same transaction", d, 8'hB3);
    check("R9 pump off", pumpOn, 0);
    endTxn();
    wr(8'h20, 8'hB8); endTxn(); wr(8'h20, 8'hB4);
    rd(8'h20, d); check("R8 code 10 clears arm", d, 8'hB3);
    wr(8'h20, 8'hB8); endTxn(); wr(8'h20, 8'hB6);
    rd(8'h20, d); check("R8 code 11 clears arm", d, 8'hB3);
    wr(8'h20, 8'hB8); endTxn(); wr(8'h20, 8'hB0);
    rd(8'h20, d); check("R8 code 00 clears arm", d, 8'hB3);
    check("R8 pump still off", pumpOn, 0);
    wr(8'h20, 8'hB8); endTxn(); wr(8'h20, 8'hB2);
    rd(8'h20, d); check("R10 field reads 00 when on", d, 8'hB1);
    check("R8 pump on", pumpOn, 1);
    wr(8'h20, 8'hB4); endTxn();
    check("R8 pump sticky", pumpOn, 1);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule